// File: doc/BRIEF.md
# SPI NOR Flash Command Sequencer

This block is the byte-level command engine of a serial NOR flash slave. A bit shifter, which lies outside the block, hands it one received byte per transfer as a single-cycle `rx_valid` strobe. It also signals each chip-select assertion with a `cs_start` pulse. The sequencer decodes the first byte after chip select as an opcode. It then gathers the address, mode and dummy bytes that follow, and moves into a streaming read, a page-program stream or a short reply. The reply byte for a transfer is registered and appears on `tx_byte` one cycle after the strobe. The shifter sends it on the next transfer.

The sequencer holds no array of its own. During a read it drives the current address on `mem_addr` and takes the byte at that address from `mem_rdata`. It reports program bytes and erase commands as single-cycle request pulses. The block also keeps the write-enable latch and serves the status byte and the identification bytes from parameters.

States: `ST_IDLE` (each byte is an opcode), `ST_COLLECT` (gathering post-opcode bytes), `ST_READ` (streaming storage bytes), `ST_PROG` (streaming program bytes), `ST_REPLY` (returning status or ID bytes). The transitions are:
- idle to collect on an addressed opcode;
- idle to reply on a status or ID opcode;
- collect to read, to program or to idle when the last byte is collected;
- reply to idle after the last reply byte;
- any state to idle on `cs_start`.

Top module: `spi_nor_cmd_seq`

## Requirements
- R1: After reset the machine is idle, `tx_byte` is 0x00, no request or error pulse is raised, and the write-enable latch is clear.
- R2: After the opcode, erase (0x20, 0x52, 0xD8), read (0x03) and program (0x02, 0xA2, 0x32) each collect 3 bytes. Fast read (0x0B), dual output read (0x3B) and quad output read (0x6B) each collect 4 bytes.
- R3: Dual I/O read (0xBB) collects 4 bytes when `MFR_ID` is 0xEF or 0x01, and 5 bytes otherwise. Quad I/O read (0xEB) collects 6 bytes for those IDs and 8 bytes otherwise.
- R4: The address is formed from the first three collected bytes, most significant first: byte 0 gives bits 23:16, byte 1 gives bits 15:8 and byte 2 gives bits 7:0.
- R5: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Opcode 0x05 returns one byte with the latch in bit 1 and all other bits zero.
- R6: Opcode 0x9F returns `MFR_ID`, then the high and the low byte of `DEV_ID`. When `EXT_ID` is non-zero it then returns the high and the low byte of `EXT_ID`. After the last byte the machine is idle.
- R7: Write status (0x01) with the latch set collects 1 byte and then clears the latch. With the latch clear the opcode is ignored, and the next byte is decoded as an opcode.
- R8: A `cs_start` pulse aborts any command, clears the byte counters and returns the machine to idle.
- R9: In the read state each transfer returns `mem_rdata` for the current `mem_addr` and pulses `rd_strobe`. The address then advances by one modulo 2^`SIZE_LOG2`.
- R10: In the program state each transfer pulses `prog_req` with the received byte on `prog_data` and the current address on `req_addr`. The address then advances by one without wrapping.
- R11: With the latch set, an erase pulses `erase_req` with `req_addr`, and `erase_kind` is 0 for 0x20, 1 for 0x52, 2 for 0xD8 and 3 for 0xC7. A block erase is issued after its third address byte; chip erase (0xC7) is issued on its opcode with address 0. With the latch clear, `protect_err` pulses instead and no erase is issued.
- R12: An opcode outside the set pulses `bad_opcode` and leaves the machine idle. Opcode 0x00 does nothing.
- R13: `tx_byte` is 0x00 after every transfer made in the idle, collect or program state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_start | input | 1 | Pulse on each chip-select assertion |
| rx_valid | input | 1 | One-cycle strobe: a received byte is present |
| rx_byte | input | 8 | Received byte |
| tx_byte | output | 8 | Reply byte for the last transfer (registered) |
| mem_addr | output | 24 | Current address presented to storage |
| mem_rdata | input | 8 | Storage byte at `mem_addr` |
| rd_strobe | output | 1 | Pulse: one read byte consumed |
| prog_req | output | 1 | Pulse: program one byte |
| prog_data | output | 8 | Byte to program |
| req_addr | output | 24 | Address of a program or erase request |
| erase_req | output | 1 | Pulse: erase request |
| erase_kind | output | 2 | Erase size code (see R11) |
| bad_opcode | output | 1 | Pulse: unknown opcode |
| protect_err | output | 1 | Pulse: erase refused, latch clear |

## Verification
The bench builds two copies of the block and drives both with the same input bytes. The first copy has `MFR_ID` 0x3C, a non-zero `EXT_ID` and `SIZE_LOG2` of 12. The second has `MFR_ID` 0xEF and a zero `EXT_ID`. Because both copies see the same bytes, each I/O read count (5 and 4, 8 and 6) and both ID lengths (5 and 3 bytes) can be checked. The 4 KiB size lets a read run from 0xFFF back to 0x000 in two transfers, while a program stream is seen to cross into 0x1000.

// File: rtl/spi_nor_seq_pkg.sv
package spi_nor_seq_pkg;

    localparam int ADDR_BYTES = 3;
    localparam int ADDR_W     = 8 * ADDR_BYTES;
    localparam int NEED_W     = 4;

    localparam logic [7:0] OPC_NOP      = 8'h00;
    localparam logic [7:0] OPC_WRSTAT   = 8'h01;
    localparam logic [7:0] OPC_PROG     = 8'h02;
    localparam logic [7:0] OPC_READ     = 8'h03;
    localparam logic [7:0] OPC_WRDIS    = 8'h04;
    localparam logic [7:0] OPC_RDSTAT   = 8'h05;
    localparam logic [7:0] OPC_WREN     = 8'h06;
    localparam logic [7:0] OPC_FREAD    = 8'h0B;
    localparam logic [7:0] OPC_ERASE_S  = 8'h20;
    localparam logic [7:0] OPC_PROG_Q   = 8'h32;
    localparam logic [7:0] OPC_READ_DO  = 8'h3B;
    localparam logic [7:0] OPC_ERASE_M  = 8'h52;
    localparam logic [7:0] OPC_READ_QO  = 8'h6B;
    localparam logic [7:0] OPC_RDID     = 8'h9F;
    localparam logic [7:0] OPC_PROG_D   = 8'hA2;
    localparam logic [7:0] OPC_READ_DIO = 8'hBB;
    localparam logic [7:0] OPC_CHIPERS  = 8'hC7;
    localparam logic [7:0] OPC_ERASE_L  = 8'hD8;
    localparam logic [7:0] OPC_READ_QIO = 8'hEB;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_READ,
        ST_COLLECT,
        ST_REPLY
    } seq_state_e;

    typedef enum logic [3:0] {
        CMD_NOP,
        CMD_BAD,
        CMD_WREN,
        CMD_WRDI,
        CMD_RDSR,
        CMD_RDID,
        CMD_CHIP_ERASE,
        CMD_READ,
        CMD_PROG,
        CMD_ERASE,
        CMD_WRSTAT
    } cmd_class_e;

    typedef enum logic [1:0] {
        ERK_4K     = 2'd0,
        ERK_32K    = 2'd1,
        ERK_SECTOR = 2'd2,
        ERK_CHIP   = 2'd3
    } erase_kind_e;

endpackage

// File: rtl/spi_nor_opdec.sv
module spi_nor_opdec
    import spi_nor_seq_pkg::*;
#(
    parameter logic [7:0] MFR_ID = 8'h3C
) (
    input  logic [7:0]        opcode,
    output cmd_class_e        cls,
    output logic [NEED_W-1:0] need,
    output erase_kind_e       kind
);

    localparam bit WIDE_IO = (MFR_ID == 8'hEF) || (MFR_ID == 8'h01);

    logic [NEED_W-1:0] dio_need;
    logic [NEED_W-1:0] qio_need;

    generate
        if (WIDE_IO) begin : g_short_io
            assign dio_need = NEED_W'(4);
            assign qio_need = NEED_W'(6);
        end else begin : g_long_io
            assign dio_need = NEED_W'(5);
            assign qio_need = NEED_W'(8);
        end
    endgenerate

    always_comb begin
        cls  = CMD_BAD;
        need = '0;
        kind = ERK_4K;
        case (opcode)
            OPC_NOP:      cls = CMD_NOP;
            OPC_WREN:     cls = CMD_WREN;
            OPC_WRDIS:    cls = CMD_WRDI;
            OPC_RDSTAT:   cls = CMD_RDSR;
            OPC_RDID:     cls = CMD_RDID;
            OPC_CHIPERS:  begin cls = CMD_CHIP_ERASE; kind = ERK_CHIP; end
            OPC_WRSTAT:   begin cls = CMD_WRSTAT; need = NEED_W'(1); end
            OPC_READ:     begin cls = CMD_READ; need = NEED_W'(3); end
            OPC_FREAD,
            OPC_READ_DO,
            OPC_READ_QO:  begin cls = CMD_READ; need = NEED_W'(4); end
            OPC_READ_DIO: begin cls = CMD_READ; need = dio_need; end
            OPC_READ_QIO: begin cls = CMD_READ; need = qio_need; end
            OPC_PROG,
            OPC_PROG_D,
            OPC_PROG_Q:   begin cls = CMD_PROG; need = NEED_W'(3); end
            OPC_ERASE_S:  begin cls = CMD_ERASE; need = NEED_W'(3); kind = ERK_4K; end
            OPC_ERASE_M:  begin cls = CMD_ERASE; need = NEED_W'(3); kind = ERK_32K; end
            OPC_ERASE_L:  begin cls = CMD_ERASE; need = NEED_W'(3); kind = ERK_SECTOR; end
            default:      cls = CMD_BAD;
        endcase
    end

endmodule

// File: rtl/spi_nor_collect.sv
module spi_nor_collect
    import spi_nor_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              start,
    input  logic [NEED_W-1:0] need_in,
    input  logic              take,
    input  logic [7:0]        byte_in,
    output logic              done,
    output logic [ADDR_W-1:0] addr_out
);

    logic [NEED_W-1:0] cnt_q;
    logic [NEED_W-1:0] need_q;
    logic [7:0]        abyte_q [ADDR_BYTES];

    assign done = take && (cnt_q == need_q - NEED_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            need_q <= '0;
        end else if (clear) begin
            cnt_q  <= '0;
        end else if (start) begin
            cnt_q  <= '0;
            need_q <= need_in;
        end else if (take) begin
            cnt_q  <= done ? '0 : cnt_q + NEED_W'(1);
        end
    end

    generate
        for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_abyte
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    abyte_q[i] <= '0;
                end else if (take && !clear && (cnt_q == NEED_W'(i))) begin
                    abyte_q[i] <= byte_in;
                end
            end
            // the final address byte is taken straight from the input when it completes the address
            assign addr_out[ADDR_W-1-8*i -: 8] =
                (cnt_q == NEED_W'(i)) ? byte_in : abyte_q[i];
        end
    endgenerate

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (need_q != '0) |-> (cnt_q < need_q));

endmodule

// File: rtl/spi_nor_reply.sv
module spi_nor_reply #(
    parameter logic [23:0] ID_CODE  = 24'h3C7115,
    parameter logic [15:0] EXT_CODE = 16'h0000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       load_status,
    input  logic       load_id,
    input  logic       wel,
    input  logic       advance,
    output logic [7:0] byte_out,
    output logic       last
);

    localparam int          BUF_D    = 8;
    localparam logic [2:0]  ID_LEN   = (EXT_CODE != 16'h0000) ? 3'd5 : 3'd3;

    logic [7:0] rbuf_q [BUF_D];
    logic [2:0] pos_q;
    logic [2:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
            len_q <= '0;
            for (int i = 0; i < BUF_D; i++) rbuf_q[i] <= '0;
        end else if (clear) begin
            pos_q <= '0;
            len_q <= '0;
        end else if (load_status) begin
            rbuf_q[0] <= {6'b0, wel, 1'b0};
            len_q     <= 3'd1;
            pos_q     <= '0;
        end else if (load_id) begin
            rbuf_q[0] <= ID_CODE[23:16];
            rbuf_q[1] <= ID_CODE[15:8];
            rbuf_q[2] <= ID_CODE[7:0];
            rbuf_q[3] <= EXT_CODE[15:8];
            rbuf_q[4] <= EXT_CODE[7:0];
            len_q     <= ID_LEN;
            pos_q     <= '0;
        end else if (advance) begin
            pos_q <= last ? 3'd0 : pos_q + 3'd1;
        end
    end

    assign byte_out = rbuf_q[pos_q];
    assign last     = (pos_q == len_q - 3'd1);

    assert_pos_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q != 3'd0) |-> (pos_q < len_q));

endmodule

// File: rtl/spi_nor_cmd_seq.sv
module spi_nor_cmd_seq
    import spi_nor_seq_pkg::*;
#(
    parameter logic [7:0]  MFR_ID    = 8'h3C,
    parameter logic [15:0] DEV_ID    = 16'h7115,
    parameter logic [15:0] EXT_ID    = 16'h0000,
    parameter int          SIZE_LOG2 = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_start,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    output logic [7:0]  tx_byte,
    output logic [23:0] mem_addr,
    input  logic [7:0]  mem_rdata,
    output logic        rd_strobe,
    output logic        prog_req,
    output logic [7:0]  prog_data,
    output logic [23:0] req_addr,
    output logic        erase_req,
    output logic [1:0]  erase_kind,
    output logic        bad_opcode,
    output logic        protect_err
);

    localparam logic [ADDR_W:0]   SIZE_BYTES = (ADDR_W + 1)'(1) << SIZE_LOG2;
    localparam logic [ADDR_W-1:0] WRAP_MASK  = ADDR_W'(SIZE_BYTES - 1'b1);

    seq_state_e  state_q, state_d;
    cmd_class_e  cls_q, cls_d;
    erase_kind_e kind_q, kind_d;
    logic        wel_q, wel_d;
    logic [ADDR_W-1:0] addr_q, addr_d;

    cmd_class_e        dec_cls;
    logic [NEED_W-1:0] dec_need;
    erase_kind_e       dec_kind;

    logic              col_start, col_take, col_done;
    logic [ADDR_W-1:0] col_addr;
    logic              rep_status, rep_id, rep_adv, rep_last;
    logic [7:0]        rep_byte;

    logic [7:0]        tx_d, pdata_d;
    logic [ADDR_W-1:0] raddr_d;
    logic [1:0]        ekind_d;
    logic              rd_d, prog_d, er_d, bad_d, prot_d;

    spi_nor_opdec #(.MFR_ID(MFR_ID)) u_dec (
        .opcode (rx_byte),
        .cls    (dec_cls),
        .need   (dec_need),
        .kind   (dec_kind)
    );

    spi_nor_collect u_col (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cs_start),
        .start    (col_start),
        .need_in  (dec_need),
        .take     (col_take),
        .byte_in  (rx_byte),
        .done     (col_done),
        .addr_out (col_addr)
    );

    spi_nor_reply #(.ID_CODE({MFR_ID, DEV_ID}), .EXT_CODE(EXT_ID)) u_rep (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (cs_start),
        .load_status (rep_status),
        .load_id     (rep_id),
        .wel         (wel_q),
        .advance     (rep_adv),
        .byte_out    (rep_byte),
        .last        (rep_last)
    );

    assign mem_addr = addr_q;

    // next-state and control decode
    always_comb begin
        state_d    = state_q;
        cls_d      = cls_q;
        kind_d     = kind_q;
        wel_d      = wel_q;
        addr_d     = addr_q;
        col_start  = 1'b0;
        col_take   = 1'b0;
        rep_status = 1'b0;
        rep_id     = 1'b0;
        rep_adv    = 1'b0;
        tx_d       = tx_byte;
        pdata_d    = prog_data;
        raddr_d    = req_addr;
        ekind_d    = erase_kind;
        rd_d       = 1'b0;
        prog_d     = 1'b0;
        er_d       = 1'b0;
        bad_d      = 1'b0;
        prot_d     = 1'b0;
        if (cs_start) begin
            state_d = ST_IDLE;
            tx_d    = 8'h00;
        end else if (rx_valid) begin
            tx_d = 8'h00;
            unique case (state_q)
                ST_IDLE: begin
                    cls_d  = dec_cls;
                    kind_d = dec_kind;
                    case (dec_cls)
                        CMD_WREN: wel_d = 1'b1;
                        CMD_WRDI: wel_d = 1'b0;
                        CMD_RDSR: begin rep_status = 1'b1; state_d = ST_REPLY; end
                        CMD_RDID: begin rep_id = 1'b1; state_d = ST_REPLY; end
                        CMD_CHIP_ERASE: begin
                            if (wel_q) begin
                                er_d    = 1'b1;
                                ekind_d = ERK_CHIP;
                                raddr_d = '0;
                            end else begin
                                prot_d = 1'b1;
                            end
                        end
                        CMD_READ, CMD_PROG, CMD_ERASE: begin
                            col_start = 1'b1;
                            state_d   = ST_COLLECT;
                        end
                        CMD_WRSTAT: begin
                            if (wel_q) begin
                                col_start = 1'b1;
                                state_d   = ST_COLLECT;
                            end
                        end
                        CMD_BAD: bad_d = 1'b1;
                        default: ;
                    endcase
                end
                ST_COLLECT: begin
                    col_take = 1'b1;
                    if (col_done) begin
                        state_d = ST_IDLE;
                        case (cls_q)
                            CMD_READ: begin addr_d = col_addr; state_d = ST_READ; end
                            CMD_PROG: begin addr_d = col_addr; state_d = ST_PROG; end
                            CMD_ERASE: begin
                                if (wel_q) begin
                                    er_d    = 1'b1;
                                    ekind_d = kind_q;
                                    raddr_d = col_addr;
                                end else begin
                                    prot_d = 1'b1;
                                end
                            end
                            CMD_WRSTAT: wel_d = 1'b0;
                            default: ;
                        endcase
                    end
                end
                ST_READ: begin
                    tx_d   = mem_rdata;
                    rd_d   = 1'b1;
                    addr_d = (addr_q + 1'b1) & WRAP_MASK;
                end
                ST_PROG: begin
                    prog_d  = 1'b1;
                    pdata_d = rx_byte;
                    raddr_d = addr_q;
                    addr_d  = addr_q + 1'b1;
                end
                ST_REPLY: begin
                    tx_d    = rep_byte;
                    rep_adv = 1'b1;
                    if (rep_last) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cls_q   <= CMD_NOP;
            kind_q  <= ERK_4K;
            wel_q   <= 1'b0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            cls_q   <= cls_d;
            kind_q  <= kind_d;
            wel_q   <= wel_d;
            addr_q  <= addr_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_byte     <= 8'h00;
            rd_strobe   <= 1'b0;
            prog_req    <= 1'b0;
            prog_data   <= 8'h00;
            req_addr    <= '0;
            erase_req   <= 1'b0;
            erase_kind  <= 2'd0;
            bad_opcode  <= 1'b0;
            protect_err <= 1'b0;
        end else begin
            tx_byte     <= tx_d;
            rd_strobe   <= rd_d;
            prog_req    <= prog_d;
            prog_data   <= pdata_d;
            req_addr    <= raddr_d;
            erase_req   <= er_d;
            erase_kind  <= ekind_d;
            bad_opcode  <= bad_d;
            protect_err <= prot_d;
        end
    end

    assert_cs_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_start |=> (state_q == ST_IDLE));

    assert_erase_wel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> wel_q);

    assert_erase_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(erase_req && protect_err));

    assert_tx_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cs_start &&
         (state_q == ST_IDLE || state_q == ST_COLLECT || state_q == ST_PROG))
        |=> (tx_byte == 8'h00));

    assert_bad_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bad_opcode |-> (state_q == ST_IDLE));

    assert_read_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cs_start && state_q == ST_READ) |=> (mem_addr <= WRAP_MASK));

endmodule

// File: tb/test_spi_nor_cmd_seq.sv
module test_spi_nor_cmd_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 63;

    // {cs_before, req, rx, expected tx}
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 4'd1,  8'h05, 8'h00},   // R1 status opcode
        {1'b0, 4'd1,  8'hFF, 8'h00},   // R1 latch clear after reset
        {1'b0, 4'd5,  8'h06, 8'h00},   // R5 set latch
        {1'b0, 4'd5,  8'h05, 8'h00},
        {1'b0, 4'd5,  8'h00, 8'h02},   // R5 bit 1 set
        {1'b0, 4'd6,  8'h9F, 8'h00},   // R6 ID
        {1'b0, 4'd6,  8'h00, 8'h3C},
        {1'b0, 4'd6,  8'h00, 8'h71},
        {1'b0, 4'd6,  8'h00, 8'h15},
        {1'b0, 4'd6,  8'h00, 8'hA5},
        {1'b0, 4'd6,  8'h00, 8'hC3},
        {1'b0, 4'd6,  8'h05, 8'h00},   // R6 idle after 5 bytes
        {1'b0, 4'd6,  8'h00, 8'h02},
        {1'b0, 4'd4,  8'h03, 8'h00},   // R4 read at 0x000123
        {1'b0, 4'd13, 8'h00, 8'h00},   // R13 collect quiet
        {1'b0, 4'd13, 8'h01, 8'h00},
        {1'b0, 4'd13, 8'h23, 8'h00},
        {1'b0, 4'd4,  8'hFF, 8'h78},
        {1'b0, 4'd9,  8'hFF, 8'h7F},   // R9 increment
        {1'b1, 4'd9,  8'h03, 8'h00},   // R9 wrap at 0xFFF
        {1'b0, 4'd9,  8'h00, 8'h00},
        {1'b0, 4'd9,  8'h0F, 8'h00},
        {1'b0, 4'd9,  8'hFF, 8'h00},
        {1'b0, 4'd9,  8'h00, 8'hAA},
        {1'b0, 4'd9,  8'h00, 8'h5A},
        {1'b1, 4'd3,  8'hBB, 8'h00},   // R3 dual I/O, 5 bytes
        {1'b0, 4'd3,  8'h00, 8'h00},
        {1'b0, 4'd3,  8'h02, 8'h00},
        {1'b0, 4'd3,  8'h34, 8'h00},
        {1'b0, 4'd3,  8'hFF, 8'h00},
        {1'b0, 4'd3,  8'hFF, 8'h00},
        {1'b0, 4'd3,  8'h00, 8'h6C},
        {1'b1, 4'd3,  8'hEB, 8'h00},   // R3 quad I/O, 8 bytes
        {1'b0, 4'd3,  8'h00, 8'h00},
        {1'b0, 4'd3,  8'h03, 8'h00},
        {1'b0, 4'd3,  8'h45, 8'h00},
        {1'b0, 4'd3,  8'hFF, 8'h00},
        {1'b0, 4'd3,  8'hFF, 8'h00},
        {1'b0, 4'd3,  8'hFF, 8'h00},
        {1'b0, 4'd3,  8'hFF, 8'h00},
        {1'b0, 4'd3,  8'hFF, 8'h00},
        {1'b0, 4'd3,  8'h00, 8'h1C},
        {1'b1, 4'd2,  8'h0B, 8'h00},   // R2 fast read, 4 bytes
        {1'b0, 4'd2,  8'h00, 8'h00},
        {1'b0, 4'd2,  8'h00, 8'h00},
        {1'b0, 4'd2,  8'h10, 8'h00},
        {1'b0, 4'd2,  8'hFF, 8'h00},
        {1'b0, 4'd2,  8'h00, 8'h4A},
        {1'b1, 4'd8,  8'h03, 8'h00},   // R8 abort mid-collect
        {1'b0, 4'd8,  8'h00, 8'h00},
        {1'b1, 4'd8,  8'h05, 8'h00},
        {1'b0, 4'd8,  8'h00, 8'h02},
        {1'b1, 4'd7,  8'h01, 8'h00},   // R7 write status with latch
        {1'b0, 4'd7,  8'hAA, 8'h00},
        {1'b0, 4'd7,  8'h05, 8'h00},
        {1'b0, 4'd7,  8'h00, 8'h00},
        {1'b1, 4'd7,  8'h01, 8'h00},   // R7 ignored with latch clear
        {1'b0, 4'd7,  8'h9F, 8'h00},
        {1'b0, 4'd7,  8'h00, 8'h3C},
        {1'b1, 4'd5,  8'h06, 8'h00},   // R5 clear latch
        {1'b0, 4'd5,  8'h04, 8'h00},
        {1'b0, 4'd5,  8'h05, 8'h00},
        {1'b0, 4'd5,  8'h00, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_start = 1'b0;
    logic rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;

    logic [7:0]  tx_a, tx_b, rdata_a, rdata_b, pdata_a, pdata_b;
    logic [23:0] maddr_a, maddr_b, raddr_a, raddr_b;
    logic        rds_a, rds_b, prq_a, prq_b, erq_a, erq_b, bad_a, bad_b, prot_a, prot_b;
    logic [1:0]  ek_a, ek_b;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign rdata_a = maddr_a[7:0] ^ maddr_a[15:8] ^ 8'h5A;
    assign rdata_b = maddr_b[7:0] ^ maddr_b[15:8] ^ 8'h5A;

    spi_nor_cmd_seq #(.MFR_ID(8'h3C), .DEV_ID(16'h7115), .EXT_ID(16'hA5C3), .SIZE_LOG2(12))
    i_spi_nor_cmd_seq (
        .clk(clk), .rst_n(rst_n), .cs_start(cs_start), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_byte(tx_a), .mem_addr(maddr_a), .mem_rdata(rdata_a), .rd_strobe(rds_a),
        .prog_req(prq_a), .prog_data(pdata_a), .req_addr(raddr_a), .erase_req(erq_a),
        .erase_kind(ek_a), .bad_opcode(bad_a), .protect_err(prot_a)
    );

    spi_nor_cmd_seq #(.MFR_ID(8'hEF), .DEV_ID(16'h6A21), .EXT_ID(16'h0000), .SIZE_LOG2(12))
    i_spi_nor_cmd_seq_wide (
        .clk(clk), .rst_n(rst_n), .cs_start(cs_start), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_byte(tx_b), .mem_addr(maddr_b), .mem_rdata(rdata_b), .rd_strobe(rds_b),
        .prog_req(prq_b), .prog_data(pdata_b), .req_addr(raddr_b), .erase_req(erq_b),
        .erase_kind(ek_b), .bad_opcode(bad_b), .protect_err(prot_b)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pulse_cs;
        @(negedge clk);
        cs_start = 1'b1;
        @(negedge clk);
        cs_start = 1'b0;
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 tx after reset", tx_a, 8'h00);
        check("R1 pulses after reset", {rds_a, prq_a, erq_a, bad_a, prot_a}, 5'b0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][20]) pulse_cs();
            xfer(VEC[i][15:8]);
            check($sformatf("R%0d table row %0d", VEC[i][19:16], i), tx_a, VEC[i][7:0]);
        end

        // R10 program stream, no wrap past the array size
        pulse_cs();
        xfer(8'h02); xfer(8'h00); xfer(8'h0F); xfer(8'hFE);
        xfer(8'h11);
        check("R10 prog pulse", prq_a, 1'b1);
        check("R10 prog data", pdata_a, 8'h11);
        check("R10 prog addr", raddr_a, 24'h000FFE);
        check("R13 tx in program", tx_a, 8'h00);
        xfer(8'h22);
        check("R10 prog addr 2", raddr_a, 24'h000FFF);
        xfer(8'h33);
        check("R10 prog addr no wrap", raddr_a, 24'h001000);
        check("R10 prog data 3", pdata_a, 8'h33);

        // R11 erase refused with latch clear
        pulse_cs();
        xfer(8'h20); xfer(8'h00); xfer(8'h12); xfer(8'h34);
        check("R11 protect pulse", prot_a, 1'b1);
        check("R11 no erase without latch", erq_a, 1'b0);

        pulse_cs();
        xfer(8'h06);
        xfer(8'h52); xfer(8'h00); xfer(8'h56);
        check("R11 no erase before last addr byte", erq_a, 1'b0);
        xfer(8'h78);
        check("R11 erase 32K pulse", erq_a, 1'b1);
        check("R11 erase 32K kind", ek_a, 2'd1);
        check("R4 erase addr", raddr_a, 24'h005678);

        pulse_cs();
        xfer(8'hD8); xfer(8'h9A); xfer(8'hBC); xfer(8'hDE);
        check("R11 sector kind", {erq_a, ek_a}, 3'b110);
        check("R4 sector addr", raddr_a, 24'h9ABCDE);

        pulse_cs();
        xfer(8'hC7);
        check("R11 chip erase", {erq_a, ek_a}, 3'b111);
        check("R11 chip erase addr", raddr_a, 24'h000000);
        xfer(8'h04);
        xfer(8'hC7);
        check("R11 chip erase refused", {erq_a, prot_a}, 2'b01);

        // R12 unknown opcode and no-op
        pulse_cs();
        xfer(8'h77);
        check("R12 bad opcode pulse", bad_a, 1'b1);
        xfer(8'h05);
        xfer(8'h00);
        check("R12 idle after bad opcode", tx_a, 8'h00);
        xfer(8'h00);
        check("R12 no-op raises nothing", {bad_a, prot_a, erq_a}, 3'b0);

        // R6 three-byte ID on the second build
        pulse_cs();
        xfer(8'h9F);
        xfer(8'h00); check("R6 wide id byte0", tx_b, 8'hEF);
        xfer(8'h00); check("R6 wide id byte1", tx_b, 8'h6A);
        xfer(8'h00); check("R6 wide id byte2", tx_b, 8'h21);
        xfer(8'h06);
        xfer(8'h05);
        xfer(8'h00);
        check("R6 idle after 3 id bytes", tx_b, 8'h02);

        // R3 short I/O read counts
        pulse_cs();
        xfer(8'hBB); xfer(8'h00); xfer(8'h01); xfer(8'h00); xfer(8'hFF);
        xfer(8'h00);
        check("R3 dual io 4 bytes", tx_b, 8'h5B);
        check("R9 read strobe", rds_b, 1'b1);

        pulse_cs();
        xfer(8'hEB); xfer(8'h00); xfer(8'h02); xfer(8'h00);
        xfer(8'hFF); xfer(8'hFF); xfer(8'hFF);
        xfer(8'h00);
        check("R3 quad io 6 bytes", tx_b, 8'h58);

        finished = 1'b1;
        report();
    end

endmodule